// File: doc/BRIEF.md
# Short-Packet Queue and Interrupt Register Block

This block is the register-mapped control and status front end for a camera-serial transmitter. Software writes generic short-packet words to a command register. Each word is checked for a legal generic data type. A legal word goes into a small first-in first-out queue, and a downstream packet inserter takes words out of the head of that queue. Software can read the fill level of the queue at any time. A read-only word reports how many lanes the transmitter was built with.

Three sticky event flags record problems: a word with an illegal data type, a word that arrived while the queue was full, and a line-buffer overflow reported by the datapath. Software clears a flag by writing one to it. Two of the flags have enable bits, and those enable bits gate the flags onto a single registered interrupt line. The line-buffer overflow flag has no enable bit, so it is recorded but never raises the interrupt.

The register port is word-addressed with 10 address bits. Bits [9:8] pick a region. Only region 0 holds these registers. Read data is registered.

Top module: `spq_csr_top`

## Requirements
- R1: After a synchronous reset, every flag and enable bit is zero, the queue is empty (`pkt_valid` low, fill level 0) and `irq` is low.
- R2: A read of offset 0x000 returns the lane count minus one in bits [2:0] (3 for the default of four lanes) and zero in all other bits.
- R3: A write to offset 0x034 whose data type, bits [21:16], is in 0x08..0x0F stores bits [25:0] as one queue entry, and bits [31:26] are ignored. The head entry is shown on `pkt_data` while `pkt_valid` is high. A cycle with `pkt_pop` high removes it. Entries leave in the order they were written.
- R4: A read of offset 0x004 returns the current queue fill level in bits [4:0], from 0 up to 16.
- R5: A legal-type write while the queue holds 16 entries is dropped, and it sets flag bit 1 of offset 0x010. Fullness is judged before any pop in the same cycle.
- R6: A write to 0x034 whose data type is outside 0x08..0x0F is dropped and sets flag bit 2. It does not set bit 1, even when the queue is full.
- R7: A one-cycle pulse on `lbuf_ovf` sets flag bit 0.
- R8: At offset 0x010, writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A read returns the flags in bits [2:0].
- R9: Offset 0x020 holds enable bits [2:1], which can be read back. Bit 0 and bits [31:3] always read zero.
- R10: `irq` is a register equal to the OR over bits 2 and 1 of (flag AND enable). It follows the flags one cycle later, and flag bit 0 never raises it.
- R11: When a hardware event sets a flag in the same cycle that software writes 1 to clear it, the flag ends up set.
- R12: Accesses with address bits [9:8] not equal to 0 have no effect on any register or on the queue, and reads of them return zero.
- R13: `reg_rdata` is loaded on the clock edge that samples `reg_rd` high, and it holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 10 | Word address; bits [9:8] select the region |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| lbuf_ovf | input | 1 | Line-buffer overflow event pulse |
| pkt_pop | input | 1 | Inserter takes the head queue entry |
| pkt_valid | output | 1 | Queue is not empty |
| pkt_data | output | 26 | Head queue entry |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a hardware set and a software clear landing on the same flag in the same cycle. The register port carries only one access per cycle, so only flag bit 0 can be contested from outside. The bench drives an `lbuf_ovf` pulse and a write-one-to-clear of bit 0 on the same clock edge, with the flag already set. It then reads the flag back. Queue-full behaviour is reached by writing sixteen legal words and then a seventeenth word. The bench then drains all sixteen entries to show that the seventeenth word never entered the queue.

// File: rtl/spq_pkg.sv
package spq_pkg;
  localparam int REG_AW = 10;
  localparam int REG_DW = 32;
  localparam int PKT_W  = 26;

  localparam logic [1:0] REGION_CSR = 2'b00;

  localparam logic [7:0] OFF_LANES  = 8'h00;
  localparam logic [7:0] OFF_FILL   = 8'h04;
  localparam logic [7:0] OFF_FLAGS  = 8'h10;
  localparam logic [7:0] OFF_ENABLE = 8'h20;
  localparam logic [7:0] OFF_PUSH   = 8'h34;

  localparam int DT_LSB = 16;
  localparam int DT_W   = 6;
  localparam logic [DT_W-1:0] DT_LO = 6'h08;
  localparam logic [DT_W-1:0] DT_HI = 6'h0F;

  localparam int NFLAG    = 3;
  localparam int FLG_LBUF = 0;
  localparam int FLG_FULL = 1;
  localparam int FLG_DT   = 2;
endpackage

// File: rtl/spq_fifo.sv
module spq_fifo #(
  parameter int WIDTH = 26,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             valid_o,
  output logic             full_o,
  output logic [CW-1:0]    level_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    count;
  logic             pop;

  assign pop     = pop_i && (count != '0);
  assign valid_o = (count != '0);
  assign full_o  = (count == CW'(DEPTH));
  assign level_o = count;
  assign head_o  = mem[rp];

  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_i) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)    rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_i, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5: the owner must never push into a full queue
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    push_i |-> (count < CW'(DEPTH)));
  // R4: fill level stays within the queue depth
  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R3: a pop with no push lowers the level by exactly one
  p_pop_step_r3: assert property (@(posedge clk) disable iff (rst)
    (pop && !push_i) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/spq_dt_check.sv
module spq_dt_check #(
  parameter int W = 6,
  parameter logic [W-1:0] LO = 6'h08,
  parameter logic [W-1:0] HI = 6'h0F
) (
  input  logic [W-1:0] dt_i,
  output logic         ok_o
);
  assign ok_o = (dt_i >= LO) && (dt_i <= HI);
endmodule

// File: rtl/spq_irq.sv
module spq_irq #(
  parameter int NF = 3,
  parameter logic [NF-1:0] EN_MASK = 3'b110
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          en_we_i,
  input  logic [NF-1:0] en_d_i,
  output logic [NF-1:0] flags_o,
  output logic [NF-1:0] en_o,
  output logic          irq_o
);
  logic [NF-1:0] flags, en;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      en    <= '0;
      irq_o <= 1'b0;
    end else begin
      flags <= (flags & ~clr_i) | set_i;
      if (en_we_i) en <= en_d_i & EN_MASK;
      irq_o <= |(flags & en & EN_MASK);
    end
  end

  assign flags_o = flags;
  assign en_o    = en;

  // R11: a hardware set is never lost to a clear in the same cycle
  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((flags & $past(set_i)) == $past(set_i)));
  // R8: a clear with no competing set empties the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i[0] && !set_i[0]) |=> !flags[0]);
  // R10: with the enabled-capable flags idle the line stays low
  p_lbuf_silent_r10: assert property (@(posedge clk) disable iff (rst)
    ((flags & EN_MASK) == '0) |=> !irq_o);
  // R9: unmaskable positions never hold an enable
  p_en_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (en & ~EN_MASK) == '0);
endmodule

// File: rtl/spq_csr_top.sv
module spq_csr_top
  import spq_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              lbuf_ovf,
  input  logic              pkt_pop,
  output logic              pkt_valid,
  output logic [PKT_W-1:0]  pkt_data,
  output logic              irq
);
  logic            in_csr;
  logic [7:0]      off;
  logic            wr_push, wr_flags, wr_en;
  logic            dt_ok, q_full, do_push;
  logic [CW-1:0]   q_level;
  logic [NFLAG-1:0] set_v, clr_v, flags, en;
  logic [REG_DW-1:0] rd_mux;
  logic            unused_bits;

  assign in_csr   = (reg_addr[9:8] == REGION_CSR);
  assign off      = reg_addr[7:0];
  assign wr_push  = reg_wr && in_csr && (off == OFF_PUSH);
  assign wr_flags = reg_wr && in_csr && (off == OFF_FLAGS);
  assign wr_en    = reg_wr && in_csr && (off == OFF_ENABLE);

  spq_dt_check #(.W(DT_W), .LO(DT_LO), .HI(DT_HI)) u_dt (
    .dt_i (reg_wdata[DT_LSB +: DT_W]),
    .ok_o (dt_ok)
  );

  assign do_push = wr_push && dt_ok && !q_full;

  spq_fifo #(.WIDTH(PKT_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push_i  (do_push),
    .data_i  (reg_wdata[PKT_W-1:0]),
    .pop_i   (pkt_pop),
    .head_o  (pkt_data),
    .valid_o (pkt_valid),
    .full_o  (q_full),
    .level_o (q_level)
  );

  always_comb begin
    set_v = '0;
    set_v[FLG_LBUF] = lbuf_ovf;
    set_v[FLG_FULL] = wr_push && dt_ok && q_full;
    set_v[FLG_DT]   = wr_push && !dt_ok;
  end

  assign clr_v = wr_flags ? reg_wdata[NFLAG-1:0] : '0;

  spq_irq #(.NF(NFLAG), .EN_MASK(3'b110)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .en_we_i (wr_en),
    .en_d_i  (reg_wdata[NFLAG-1:0]),
    .flags_o (flags),
    .en_o    (en),
    .irq_o   (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (in_csr) begin
      case (off)
        OFF_LANES:  rd_mux = REG_DW'(3'(LANES - 1));
        OFF_FILL:   rd_mux = REG_DW'(q_level);
        OFF_FLAGS:  rd_mux = REG_DW'(flags);
        OFF_ENABLE: rd_mux = REG_DW'(en);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign unused_bits = ^{reg_wdata[REG_DW-1:PKT_W]};

  // R6: an illegal type never changes the queue level without a pop
  p_drop_unsup_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_push && !dt_ok && !pkt_pop) |=> (q_level == $past(q_level)));
  // R12: accesses outside region 0 leave the queue untouched
  p_region_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_addr[9:8] != REGION_CSR && !pkt_pop) |=> $stable(q_level));
  // R13: read data only moves on a read cycle
  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/sim_spq_csr_top.sv
`timescale 1ns/1ps
module sim_spq_csr_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [9:0]  reg_addr;
  logic        reg_wr, reg_rd, lbuf_ovf, pkt_pop;
  logic [31:0] reg_wdata, reg_rdata;
  logic        pkt_valid, irq;
  logic [25:0] pkt_data;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spq_csr_top u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .lbuf_ovf(lbuf_ovf), .pkt_pop(pkt_pop), .pkt_valid(pkt_valid),
    .pkt_data(pkt_data), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pop_chk(input string req, input logic [25:0] exp);
    @(negedge clk);
    check(req, {31'd0, pkt_valid}, 32'd1);
    check(req, {6'd0, pkt_data}, {6'd0, exp});
    pkt_pop = 1'b1;
    @(negedge clk);
    pkt_pop = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [5:0] dt, input logic [15:0] pl);
    return {6'h3F, 4'h5, dt, pl};
  endfunction

  function automatic logic [25:0] ent(input logic [5:0] dt, input logic [15:0] pl);
    return {4'h5, dt, pl};
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    check("R1 valid", {31'd0, pkt_valid}, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(10'h004, d); check("R1 fill", d, 32'd0);
    rd(10'h010, d); check("R1 flags", d, 32'd0);
    rd(10'h020, d); check("R1 enable", d, 32'd0);
  endtask

  task automatic t_lanes;
    logic [31:0] d;
    rd(10'h000, d); check("R2 lanes", d, 32'd3);
  endtask

  task automatic t_order;
    logic [31:0] d;
    wr(10'h034, mk(6'h08, 16'h1111));
    wr(10'h034, mk(6'h0F, 16'h2222));
    wr(10'h034, mk(6'h0A, 16'h3333));
    rd(10'h004, d); check("R4 fill3", d, 32'd3);
    pop_chk("R3 first", ent(6'h08, 16'h1111));
    pop_chk("R3 second", ent(6'h0F, 16'h2222));
    pop_chk("R3 third", ent(6'h0A, 16'h3333));
    @(negedge clk);
    check("R3 empty", {31'd0, pkt_valid}, 32'd0);
  endtask

  task automatic t_unsup;
    logic [31:0] d;
    wr(10'h034, mk(6'h07, 16'hAAAA));
    rd(10'h004, d); check("R6 lo fill", d, 32'd0);
    rd(10'h010, d); check("R6 lo flag", d, 32'd4);
    wr(10'h010, 32'd4);
    wr(10'h034, mk(6'h10, 16'hBBBB));
    rd(10'h004, d); check("R6 hi fill", d, 32'd0);
    rd(10'h010, d); check("R6 hi flag", d, 32'd4);
    wr(10'h010, 32'd4);
    rd(10'h010, d); check("R8 clear", d, 32'd0);
  endtask

  task automatic t_full;
    logic [31:0] d;
    wr(10'h020, 32'h0000_0002);
    for (int i = 0; i < 16; i++) wr(10'h034, mk(6'h09, 16'(i + 100)));
    rd(10'h004, d); check("R4 fill16", d, 32'd16);
    check("R10 idle", {31'd0, irq}, 32'd0);
    wr(10'h034, mk(6'h09, 16'hDEAD));
    check("R10 lag", {31'd0, irq}, 32'd0);
    @(negedge clk);
    check("R10 raise", {31'd0, irq}, 32'd1);
    rd(10'h010, d); check("R5 full flag", d, 32'd2);
    wr(10'h034, mk(6'h01, 16'hBEEF));
    rd(10'h010, d); check("R6 full+bad", d, 32'd6);
    rd(10'h004, d); check("R5 fill kept", d, 32'd16);
    wr(10'h010, 32'd6);
    @(negedge clk);
    check("R10 drop", {31'd0, irq}, 32'd0);
    for (int i = 0; i < 16; i++) pop_chk("R5 drain", ent(6'h09, 16'(i + 100)));
    @(negedge clk);
    check("R5 no extra", {31'd0, pkt_valid}, 32'd0);
  endtask

  task automatic t_lbuf;
    logic [31:0] d;
    wr(10'h020, 32'hFFFF_FFFF);
    rd(10'h020, d); check("R9 enable", d, 32'd6);
    @(negedge clk); lbuf_ovf = 1'b1;
    @(negedge clk); lbuf_ovf = 1'b0;
    rd(10'h010, d); check("R7 flag", d, 32'd1);
    check("R10 lbuf silent", {31'd0, irq}, 32'd0);
    wr(10'h010, 32'd6);
    rd(10'h010, d); check("R8 zero keeps", d, 32'd1);
    @(negedge clk);
    reg_addr = 10'h010; reg_wdata = 32'd1; reg_wr = 1'b1; lbuf_ovf = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; lbuf_ovf = 1'b0;
    rd(10'h010, d); check("R11 set wins", d, 32'd1);
    wr(10'h010, 32'd1);
    rd(10'h010, d); check("R8 one clears", d, 32'd0);
    wr(10'h020, 32'd0);
  endtask

  task automatic t_region;
    logic [31:0] d;
    wr(10'h134, mk(6'h08, 16'h5555));
    wr(10'h220, 32'd6);
    rd(10'h004, d); check("R12 no push", d, 32'd0);
    rd(10'h020, d); check("R12 no enable", d, 32'd0);
    rd(10'h100, d); check("R12 read zero", d, 32'd0);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    rd(10'h000, d); check("R13 load", d, 32'd3);
    wr(10'h034, mk(6'h08, 16'h7777));
    @(negedge clk);
    check("R13 hold", reg_rdata, 32'd3);
    rd(10'h004, d); check("R13 new", d, 32'd1);
    pop_chk("R3 single", ent(6'h08, 16'h7777));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; lbuf_ovf = 1'b0; pkt_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_lanes();
    t_order();
    t_unsup();
    t_full();
    t_lbuf();
    t_region();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule